// File: doc/BRIEF.md
# Integer Multiply-Divide Unit with Timed HI/LO Results

This block performs 32-bit signed and unsigned multiplication and division for a processor core and keeps the two result registers, HI and LO. A core issues one operation per cycle on a small command port: start a multiply or divide, move a general-register value into HI or LO, or read HI or LO back. Every multiply or divide makes the unit busy for a number of cycles. A divide always takes a fixed time. A multiply takes a time that depends on how large the first operand is.

The result of an operation is worked out when it is issued and held in a shadow pair of registers. It is copied into the visible HI and LO only when the busy count runs out. A read of HI or LO made while the unit is busy raises a stall output. The requester holds its read until the stall drops, and then it gets the new result. Divide by zero and signed overflow give fixed result patterns and raise no fault.

Top module: `muldiv_unit`

## Requirements
- R1: After a synchronous active-low reset, HI and LO both read 0 and busy is low.
- R2: A signed multiply (op_code 0) places the low 32 bits of the 64-bit two's-complement product in LO and the high 32 bits in HI.
- R3: An unsigned multiply (op_code 1) places the low half of the unsigned 64-bit product in LO and the high half in HI.
- R4: A multiply stays busy for 7 + (2 − floor(z/11)) × 4 cycles, which gives 15, 11 or 7. For the unsigned form, z is the leading-zero count of (a OR 1). For the signed form, z is the leading-zero count of ((a XOR (a shifted right arithmetically by 21)) OR 1).
- R5: A signed divide (op_code 2) or unsigned divide (op_code 3) with a nonzero divisor puts the quotient, truncated toward zero, in LO and the remainder, which takes the sign of the dividend, in HI. Either divide stays busy for 37 cycles.
- R6: A signed divide by zero sets HI to the dividend. It sets LO to 1 if the dividend is negative and to 0xFFFFFFFF otherwise.
- R7: An unsigned divide by zero sets LO to 0xFFFFFFFF and HI to the dividend.
- R8: A signed divide of 0x80000000 by 0xFFFFFFFF sets LO to 0x80000000 and HI to 0.
- R9: A move to HI (op_code 4) or to LO (op_code 5) copies op_a into that register one cycle after issue, whether or not the unit is busy. If an operation is still in flight when the move arrives, that half keeps the moved value after the operation completes.
- R10: A read of HI (op_code 6) or LO (op_code 7) raises stall in every cycle in which the busy count is nonzero. When the unit is idle, a read completes in the same cycle with no stall.
- R11: While busy, the visible HI and LO do not change except through a move. The new results appear in the cycle that busy drops, and rd_data shows the old value while a read is stalled.
- R12: A multiply or divide issued while the unit is busy discards the operation in flight and restarts the busy count with the latency of the new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A command is present this cycle |
| op_code | input | 3 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div, 4 move to HI, 5 move to LO, 6 read HI, 7 read LO |
| op_a | input | 32 | First operand (multiplicand, dividend or value to move) |
| op_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | A multiply or divide is still counting down |
| stall | output | 1 | The present read cannot complete this cycle |
| rd_data | output | 32 | Visible HI or LO, chosen by the read code |

## Verification
The multiplies use first operands with leading-zero counts in each of the three latency bands. The signed case includes a small negative value, which shows whether the sign-folding step is applied before counting. The divides use mixed signs, which separates truncation from flooring, and then zero divisors with positive and negative dividends and the single overflowing pair, each of which selects a different fixed pattern. A read issued right after a multiply tells apart a unit that stalls for the full count and exposes only the old value from one that leaks results early. A move into an in-flight operation, and a second issue over a busy divide, show whether the moved value survives completion and whether the latency restarts.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the multiply-divide unit.
// Assumes a 32-bit data path; the command code is 3 bits wide.
package muldiv_pkg;
    parameter int unsigned MD_W = 32;

    typedef enum logic [2:0] {
        MD_MULS = 3'd0,
        MD_MULU = 3'd1,
        MD_DIVS = 3'd2,
        MD_DIVU = 3'd3,
        MD_TOHI = 3'd4,
        MD_TOLO = 3'd5,
        MD_RDHI = 3'd6,
        MD_RDLO = 3'd7
    } md_op_e;

    // Count leading zero bits of a data word.
    function automatic int lead_zeros(input logic [MD_W-1:0] v);
        int n;
        logic seen;
        n = 0;
        seen = 1'b0;
        for (int i = MD_W - 1; i >= 0; i--) begin
            if (v[i]) seen = 1'b1;
            if (!seen) n = n + 1;
        end
        return n;
    endfunction

    // True for codes that start a timed arithmetic operation.
    function automatic logic is_arith(input md_op_e op);
        return (op == MD_MULS) || (op == MD_MULU) || (op == MD_DIVS) || (op == MD_DIVU);
    endfunction

    // True for the two multiply codes.
    function automatic logic is_mul(input md_op_e op);
        return (op == MD_MULS) || (op == MD_MULU);
    endfunction
endpackage

// File: rtl/md_latency.sv
`timescale 1ns/1ps
// Busy-time selector: gives the number of busy cycles for an operation.
// Divides take a fixed time; the multiply time falls in bands set by the
// leading-zero count of the first operand (sign-folded for signed multiply).
// Assumes op is valid whenever the result is used.
module md_latency
    import muldiv_pkg::*;
#(
    parameter int unsigned W          = 32,
    parameter int unsigned DIV_CYCLES = 37,
    parameter int unsigned MUL_BASE   = 7,
    parameter int unsigned MUL_STEP   = 4,
    parameter int unsigned MUL_BANDS  = 3,
    parameter int unsigned LZ_BAND    = 11,
    parameter int unsigned SIGN_SHIFT = 21,
    parameter int unsigned CW         = 6
) (
    input  md_op_e          op,
    input  logic [W-1:0]    a,
    output logic [CW-1:0]   lat
);
    logic [W-1:0] folded;
    logic [W-1:0] probe;
    int           zeros;
    int           band;

    // Build the probe word, count its leading zeros and map to a latency.
    always_comb begin
        folded = $signed(a) >>> SIGN_SHIFT;
        if (op == MD_MULS) probe = (a ^ folded) | {{(W-1){1'b0}}, 1'b1};
        else               probe = a | {{(W-1){1'b0}}, 1'b1};
        zeros = lead_zeros(probe);
        band  = zeros / LZ_BAND;
        if (band > int'(MUL_BANDS) - 1) band = int'(MUL_BANDS) - 1;
        if (op == MD_DIVS || op == MD_DIVU)
            lat = CW'(DIV_CYCLES);
        else if (is_mul(op))
            lat = CW'(int'(MUL_BASE) + (int'(MUL_BANDS) - 1 - band) * int'(MUL_STEP));
        else
            lat = '0;
    end
endmodule

// File: rtl/md_arith.sv
`timescale 1ns/1ps
// Combinational result generator for multiply and divide.
// Produces the HI/LO pair for an issued operation, including the fixed
// patterns for division by zero and for signed overflow.
// Assumes the caller only captures the outputs for arithmetic codes.
module md_arith
    import muldiv_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  md_op_e        op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  hi_res,
    output logic [W-1:0]  lo_res
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic [2*W-1:0]        prod;
    logic signed [W-1:0]   sa;
    logic signed [W-1:0]   sb;
    logic signed [W-1:0]   sq;
    logic signed [W-1:0]   sr;

    // Select the result pair for the operation code.
    always_comb begin
        prod   = '0;
        sa     = a;
        sb     = b;
        sq     = '0;
        sr     = '0;
        hi_res = '0;
        lo_res = '0;
        case (op)
            MD_MULS: begin
                prod   = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
                hi_res = prod[2*W-1:W];
                lo_res = prod[W-1:0];
            end
            MD_MULU: begin
                prod   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
                hi_res = prod[2*W-1:W];
                lo_res = prod[W-1:0];
            end
            MD_DIVS: begin
                if (b == '0) begin
                    hi_res = a;
                    lo_res = a[W-1] ? ONE : ALL_ONES;
                end else if (a == MOST_NEG && b == ALL_ONES) begin
                    hi_res = '0;
                    lo_res = MOST_NEG;
                end else begin
                    sq     = sa / sb;
                    sr     = sa % sb;
                    hi_res = sr;
                    lo_res = sq;
                end
            end
            MD_DIVU: begin
                if (b == '0) begin
                    hi_res = a;
                    lo_res = ALL_ONES;
                end else begin
                    hi_res = a % b;
                    lo_res = a / b;
                end
            end
            default: begin
                hi_res = '0;
                lo_res = '0;
            end
        endcase
    end
endmodule

// File: rtl/md_busy.sv
`timescale 1ns/1ps
// Busy down-counter. Loads the latency on issue (restarting any count in
// progress), counts down to zero, and pulses done in the last busy cycle.
// Assumes lat is at most MAX_CNT.
module md_busy #(
    parameter int unsigned MAX_CNT = 37,
    parameter int unsigned CW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [CW-1:0] lat,
    output logic [CW-1:0] cnt,
    output logic          busy,
    output logic          done
);
    localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

    // Load on issue, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (issue)       cnt <= lat;
        else if (cnt != '0)   cnt <= cnt - CNT_ONE;
    end

    // Busy level and completion pulse.
    always_comb begin
        busy = (cnt != '0);
        done = (cnt == CNT_ONE) && !issue;
    end

    // R12: the count never exceeds the longest latency.
    a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_CNT));

    // R11: without a new issue the count drops by exactly one each cycle.
    a_r11_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !issue) |=> (cnt == $past(cnt) - CNT_ONE));
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
// Multiply-divide unit top. Holds visible HI/LO and a shadow pair that
// receives each result at issue; the shadow is copied to HI/LO when the
// busy count expires. Moves write both copies at once. Reads stall while
// busy. Assumes one command per cycle and that a stalled read is held.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int unsigned W          = 32,
    parameter int unsigned DIV_CYCLES = 37,
    parameter int unsigned MUL_BASE   = 7,
    parameter int unsigned MUL_STEP   = 4,
    parameter int unsigned MUL_BANDS  = 3,
    parameter int unsigned LZ_BAND    = 11,
    parameter int unsigned SIGN_SHIFT = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         stall,
    output logic [W-1:0] rd_data
);
    localparam int unsigned MUL_MAX = MUL_BASE + (MUL_BANDS - 1) * MUL_STEP;
    localparam int unsigned MAX_CNT = (DIV_CYCLES > MUL_MAX) ? DIV_CYCLES : MUL_MAX;
    localparam int unsigned CW      = $clog2(MAX_CNT + 1);

    md_op_e         op;
    logic           issue;
    logic           is_read;
    logic [CW-1:0]  lat;
    logic [CW-1:0]  cnt;
    logic           done;
    logic [W-1:0]   hi_res;
    logic [W-1:0]   lo_res;
    logic [W-1:0]   hi_q;
    logic [W-1:0]   lo_q;
    logic [W-1:0]   hi_pend;
    logic [W-1:0]   lo_pend;

    // Decode the command.
    always_comb begin
        op      = md_op_e'(op_code);
        issue   = op_valid && is_arith(op);
        is_read = op_valid && (op == MD_RDHI || op == MD_RDLO);
    end

    md_latency #(
        .W(W), .DIV_CYCLES(DIV_CYCLES), .MUL_BASE(MUL_BASE), .MUL_STEP(MUL_STEP),
        .MUL_BANDS(MUL_BANDS), .LZ_BAND(LZ_BAND), .SIGN_SHIFT(SIGN_SHIFT), .CW(CW)
    ) i_latency (
        .op (op),
        .a  (op_a),
        .lat(lat)
    );

    md_arith #(.W(W)) i_arith (
        .op    (op),
        .a     (op_a),
        .b     (op_b),
        .hi_res(hi_res),
        .lo_res(lo_res)
    );

    md_busy #(.MAX_CNT(MAX_CNT), .CW(CW)) i_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .issue(issue),
        .lat  (lat),
        .cnt  (cnt),
        .busy (busy),
        .done (done)
    );

    // Capture results at issue, commit at expiry, apply moves on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            hi_pend <= '0;
            lo_pend <= '0;
        end else begin
            if (issue) begin
                hi_pend <= hi_res;
                lo_pend <= lo_res;
            end
            if (done) begin
                hi_q <= hi_pend;
                lo_q <= lo_pend;
            end
            if (op_valid && op == MD_TOHI) begin
                hi_q    <= op_a;
                hi_pend <= op_a;
            end
            if (op_valid && op == MD_TOLO) begin
                lo_q    <= op_a;
                lo_pend <= op_a;
            end
        end
    end

    // Read path and stall.
    always_comb begin
        rd_data = (op == MD_RDLO) ? lo_q : hi_q;
        stall   = is_read && busy;
    end

    // R9: a move reaches the visible register one cycle later.
    a_r9_move_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == MD_TOHI) |=> (hi_q == $past(op_a)));

    // R11: HI holds while more than one busy cycle remains and no move hits it.
    a_r11_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > {{(CW-1){1'b0}}, 1'b1} && !(op_valid && op == MD_TOHI)) |=> $stable(hi_q));

    // R10: a stall seen in the last busy cycle is gone in the next.
    a_r10_stall_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && cnt == {{(CW-1){1'b0}}, 1'b1}) |=> !stall);

    // R5: a divide loads the fixed divide time.
    a_r5_div_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op == MD_DIVS || op == MD_DIVU)) |=> (cnt == CW'(DIV_CYCLES)));

    // R4: a multiply loads one of the three band latencies.
    a_r4_mul_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_mul(op)) |=>
        (cnt == CW'(MUL_BASE) || cnt == CW'(MUL_BASE + MUL_STEP) || cnt == CW'(MUL_MAX)));
endmodule

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected read values, a monitor at the
// falling edge pops and compares them when a read completes.
module test_muldiv_unit;
    logic        clk;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic        busy;
    logic        stall;
    logic [31:0] rd_data;

    int tests_run;
    int tests_failed;

    logic [31:0] exp_q[$];
    string       req_q[$];

    muldiv_unit i_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .busy(busy), .stall(stall), .rd_data(rd_data)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests_run++;
        if (act !== expv) begin
            tests_failed++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    // Reference model from the requirements.
    task automatic ref_model(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b,
                             output logic [31:0] hi, output logic [31:0] lo, output int lat);
        logic [63:0] p;
        logic [31:0] pr;
        int z;
        longint sa, sb;
        if (code == 3'd0) pr = (a ^ 32'($signed(a) >>> 21)) | 32'd1;
        else              pr = a | 32'd1;
        z = 0;
        for (int i = 31; i >= 0 && !pr[i]; i--) z++;
        lat = (code >= 3'd2) ? 37 : 7 + (2 - z / 11) * 4;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (code)
            3'd0: begin p = 64'(sa * sb); hi = p[63:32]; lo = p[31:0]; end
            3'd1: begin p = {32'd0, a} * {32'd0, b}; hi = p[63:32]; lo = p[31:0]; end
            3'd2: begin
                if (b == 0) begin hi = a; lo = a[31] ? 32'd1 : 32'hFFFFFFFF; end
                else if (a == 32'h80000000 && b == 32'hFFFFFFFF) begin hi = 0; lo = 32'h80000000; end
                else begin lo = 32'(sa / sb); hi = 32'(sa % sb); end
            end
            default: begin
                if (b == 0) begin hi = a; lo = 32'hFFFFFFFF; end
                else begin lo = a / b; hi = a % b; end
            end
        endcase
    endtask

    task automatic send(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk); #1;
        op_valid = 1'b1; op_code = code; op_a = a; op_b = b;
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(posedge clk); #1;
        end
    endtask

    // Issue a read, hold it through any stall, count stalled cycles.
    task automatic do_read(input bit sel_lo, input string req, input logic [31:0] expv,
                           input logic [31:0] hold_v, input int exp_stalls);
        int n;
        exp_q.push_back(expv);
        req_q.push_back(req);
        op_valid = 1'b1; op_code = sel_lo ? 3'd7 : 3'd6;
        n = 0;
        #1;
        while (stall) begin
            n++;
            chk("R11 old value while stalled", rd_data, hold_v);
            @(posedge clk); #2;
        end
        chk("R10 stall cycles", 32'(n), 32'(exp_stalls));
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    task automatic run_arith(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b,
                             input string req);
        logic [31:0] eh, el;
        int lat, n;
        ref_model(code, a, b, eh, el, lat);
        send(code, a, b);
        wait_idle(n);
        chk((code < 3'd2) ? "R4 multiply busy time" : "R5 divide busy time", 32'(n), 32'(lat));
        do_read(1'b0, req, eh, eh, 0);
        do_read(1'b1, req, el, el, 0);
    endtask

    // Monitor: compare each completed read with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && op_valid && op_code[2:1] == 2'b11 && !stall) begin
            if (exp_q.size() == 0) begin
                tests_run++;
                tests_failed++;
                $display("FAIL R10: unexpected read completion, got %h expected none", rd_data);
            end else begin
                chk(req_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        int n;
        tests_run = 0; tests_failed = 0;
        rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; op_a = 0; op_b = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 busy after reset", 32'(busy), 32'd0);
        do_read(1'b0, "R1 HI reset", 32'd0, 32'd0, 0);
        do_read(1'b1, "R1 LO reset", 32'd0, 32'd0, 0);

        run_arith(3'd0, 32'h00001234, 32'hFFFFFFFE, "R2 signed product");
        run_arith(3'd0, 32'hFFFFFFF0, 32'h00000003, "R2 signed small negative");
        run_arith(3'd0, 32'h40000000, 32'h40000000, "R2 signed large");
        run_arith(3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, "R3 unsigned full");
        run_arith(3'd1, 32'd5, 32'd7, "R3 unsigned small");
        run_arith(3'd2, 32'hFFFFFFF9, 32'd2, "R5 signed divide");
        run_arith(3'd2, 32'd7, 32'hFFFFFFFE, "R5 signed divide neg divisor");
        run_arith(3'd3, 32'd100, 32'd7, "R5 unsigned divide");
        run_arith(3'd2, 32'd5, 32'd0, "R6 positive by zero");
        run_arith(3'd2, 32'hFFFFFFFB, 32'd0, "R6 negative by zero");
        run_arith(3'd3, 32'h80000000, 32'd0, "R7 unsigned by zero");
        run_arith(3'd2, 32'h80000000, 32'hFFFFFFFF, "R8 signed overflow");

        // R9: moves while idle
        send(3'd4, 32'h12345678, 32'd0);
        do_read(1'b0, "R9 move to HI", 32'h12345678, 32'h12345678, 0);
        send(3'd5, 32'h0BADF00D, 32'd0);
        do_read(1'b1, "R9 move to LO", 32'h0BADF00D, 32'h0BADF00D, 0);

        // R9: move into an in-flight divide survives completion
        send(3'd3, 32'd100, 32'd7);
        send(3'd5, 32'h0000CAFE, 32'd0);
        wait_idle(n);
        do_read(1'b1, "R9 move kept over completion", 32'h0000CAFE, 32'h0000CAFE, 0);
        do_read(1'b0, "R9 other half from divide", 32'd2, 32'd2, 0);

        // R10/R11: read right after a 7-cycle multiply stalls the full count
        send(3'd5, 32'h00001111, 32'd0);
        send(3'd1, 32'd5, 32'd7);
        do_read(1'b1, "R10 read after stall", 32'd35, 32'h00001111, 7);

        // R12: restart a busy divide with a short multiply
        send(3'd3, 32'd1000, 32'd3);
        @(posedge clk); #1;
        send(3'd1, 32'd6, 32'd7);
        wait_idle(n);
        chk("R12 restarted busy time", 32'(n), 32'd7);
        do_read(1'b1, "R12 LO from second op", 32'd42, 32'd42, 0);
        do_read(1'b0, "R12 HI from second op", 32'd0, 32'd0, 0);

        @(posedge clk); #1;
        chk("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule